// File: doc/BRIEF.md
# GPIO Debounce Sampling Controller

This block filters a group of general-purpose input pins before they reach interrupt detection. A shared sample counter produces a periodic sampling strobe. A 4-bit rate code sets its period to 2^code counting steps, from 1 up to 32768. The counter steps either on every system clock or only on a single-cycle slow-tick enable, which stands for a low-frequency timebase in the main clock domain.

On each strobe, every pin whose interrupt enable is set takes a new sample of its raw level. Its debounced output follows the raw level only after two consecutive samples agree. A pin whose interrupt is disabled gets no strobes and keeps its debounced level.

The sampling clock runs in two cases: the clock-enable control bit is set and the device is awake, or at least one pin has its interrupt enabled. While the sleep indication is high, the enable bit is ignored. When the sampling clock is off, the counter keeps its value. All inputs are plain levels sampled on the system clock, so there is no handshake at the edge of the block.

Top module: `gdb_debounce_top`

## Requirements
- R1: While rst_n is low at a clock edge, the sample counter, every sample history and every bit of pin_db are cleared to 0. pin_db reads 0 after reset even if pin_raw is high.
- R2: With the counter stepping on every cycle, strobes occur on the advancing cycles k = 0, 2^code, 2·2^code, … counted from reset release. The first advancing cycle always strobes. A pin held at a new level during reset therefore reaches pin_db one cycle after advancing cycle 2^code.
- R3: With ctrl_src_sel = 1, the counter steps only on cycles where slow_tick = 1, and no strobe occurs on any other cycle. With ctrl_src_sel = 0, slow_tick is ignored.
- R4: The sampling clock runs when (ctrl_clk_en = 1 and sleep = 0) or any int_en bit is 1. While it is off, the counter holds its value and no strobes occur.
- R5: While sleep = 1, ctrl_clk_en has no effect, and the sampling clock runs only if some int_en bit is 1.
- R6: A pin with int_en = 0 takes no samples, and its pin_db bit keeps its value whatever pin_raw does.
- R7: On a strobe, an enabled pin stores its raw level as its history. pin_db takes that level only if it equals the stored history from the previous strobe, so a level lasting a single sample never reaches pin_db.
- R8: A change of ctrl_code takes effect on the next advancing cycle and does not reset the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_code | input | 4 | Sample period code; period = 2^code counting steps |
| ctrl_src_sel | input | 1 | Counter step source: 0 = every clock, 1 = slow_tick only |
| ctrl_clk_en | input | 1 | Sampling clock enable (ignored while sleep = 1) |
| slow_tick | input | 1 | Single-cycle enable pulse of the slow timebase |
| sleep | input | 1 | Sleep indication |
| int_en | input | NUM_PINS | Per-pin interrupt enable; selects which pins are sampled |
| pin_raw | input | NUM_PINS | Raw pin levels |
| pin_db | output | NUM_PINS | Debounced pin levels |

## Verification
The checker holds the following properties on every cycle:
- With the sampling clock off, there are no strobes and the counter is frozen.
- No strobe falls on a non-tick cycle in slow-source mode.
- No strobe occurs in sleep without an enabled pin.
- A disabled pin, and every pin on a cycle without a strobe, keeps its debounced level.
- pin_db is cleared after reset.

Some behaviour only the bench scenarios can show:
- The exact strobe phase for each code, swept over all sixteen codes.
- That the counter keeps its phase across a gated interval and across a code change.
- Glitch rejection by the two-sample match.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  // Width of the sampling-rate code.
  localparam int GDB_CODE_W = 4;
  // Counter wide enough for the longest period, 2^(2^CODE_W - 1).
  localparam int GDB_CNT_W  = (1 << GDB_CODE_W) - 1;

  typedef logic [GDB_CODE_W-1:0] gdb_code_t;
  typedef logic [GDB_CNT_W-1:0]  gdb_cnt_t;

  typedef enum logic {
    GDB_SRC_SYS  = 1'b0,
    GDB_SRC_SLOW = 1'b1
  } gdb_src_e;

  // Mask of the low 'code' bits of the counter.
  function automatic gdb_cnt_t gdb_phase_mask(gdb_code_t code);
    gdb_cnt_t ones;
    ones = '1;
    return ~(ones << code);
  endfunction
endpackage

// File: rtl/gdb_clk_gate.sv
module gdb_clk_gate
  import gdb_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                ctrl_clk_en,
  input  logic                sleep,
  input  logic                ctrl_src_sel,
  input  logic                slow_tick,
  input  logic [NUM_PINS-1:0] int_en,
  output logic                samp_run,
  output logic                samp_adv
);
  logic any_irq;
  logic sw_on;
  logic src_step;

  always_comb begin
    any_irq = |int_en;
    // The software enable counts only while awake.
    sw_on   = ctrl_clk_en & ~sleep;
    samp_run = any_irq | sw_on;
  end

  always_comb begin
    unique case (gdb_src_e'(ctrl_src_sel))
      GDB_SRC_SYS:  src_step = 1'b1;
      GDB_SRC_SLOW: src_step = slow_tick;
      default:      src_step = 1'b0;
    endcase
    samp_adv = samp_run & src_step;
  end
endmodule

// File: rtl/gdb_strobe_gen.sv
module gdb_strobe_gen
  import gdb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      samp_adv,
  input  gdb_code_t ctrl_code,
  output logic      samp_stb,
  output gdb_cnt_t  samp_cnt
);
  gdb_cnt_t phase_mask;
  logic     phase_zero;

  always_comb begin
    phase_mask = gdb_phase_mask(ctrl_code);
    phase_zero = ((samp_cnt & phase_mask) == '0);
    samp_stb   = samp_adv & phase_zero;
  end

  // Free-running counter; holds while the sampling clock is gated.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_cnt <= '0;
    end else if (samp_adv) begin
      samp_cnt <= samp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_stb,
  input  logic raw_lvl,
  output logic db_lvl
);
  logic hist_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_lvl <= 1'b0;
      db_lvl   <= 1'b0;
    end else if (pin_stb) begin
      hist_lvl <= raw_lvl;
      if (raw_lvl == hist_lvl) begin
        db_lvl <= raw_lvl;
      end
    end
  end
endmodule

// File: rtl/gdb_debounce_top.sv
module gdb_debounce_top
  import gdb_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GDB_CODE_W-1:0] ctrl_code,
  input  logic                  ctrl_src_sel,
  input  logic                  ctrl_clk_en,
  input  logic                  slow_tick,
  input  logic                  sleep,
  input  logic [NUM_PINS-1:0]   int_en,
  input  logic [NUM_PINS-1:0]   pin_raw,
  output logic [NUM_PINS-1:0]   pin_db
);
  logic     samp_run;
  logic     samp_adv;
  logic     samp_stb;
  gdb_cnt_t samp_cnt;

  gdb_clk_gate #(.NUM_PINS(NUM_PINS)) gate_i (
    .ctrl_clk_en  (ctrl_clk_en),
    .sleep        (sleep),
    .ctrl_src_sel (ctrl_src_sel),
    .slow_tick    (slow_tick),
    .int_en       (int_en),
    .samp_run     (samp_run),
    .samp_adv     (samp_adv)
  );

  gdb_strobe_gen strobe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_adv  (samp_adv),
    .ctrl_code (ctrl_code),
    .samp_stb  (samp_stb),
    .samp_cnt  (samp_cnt)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gdb_pin_filter filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_stb (samp_stb & int_en[p]),
      .raw_lvl (pin_raw[p]),
      .db_lvl  (pin_db[p])
    );
  end
endmodule

// File: rtl/gdb_debounce_chk.sv
module gdb_debounce_chk
  import gdb_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_src_sel,
  input logic                slow_tick,
  input logic                sleep,
  input logic [NUM_PINS-1:0] int_en,
  input logic [NUM_PINS-1:0] pin_db,
  input logic                samp_run,
  input logic                samp_adv,
  input logic                samp_stb,
  input gdb_cnt_t            samp_cnt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_db == '0));

  assert_no_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_run |-> !samp_stb);

  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_adv |=> $stable(samp_cnt));

  assert_slow_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_src_sel && !slow_tick) |-> !samp_stb);

  assert_sleep_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && (int_en == '0)) |-> !samp_stb);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en[p] |=> $stable(pin_db[p]));

    assert_change_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_stb |=> $stable(pin_db[p]));
  end
endmodule

bind gdb_debounce_top gdb_debounce_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_src_sel (ctrl_src_sel),
  .slow_tick    (slow_tick),
  .sleep        (sleep),
  .int_en       (int_en),
  .pin_db       (pin_db),
  .samp_run     (samp_run),
  .samp_adv     (samp_adv),
  .samp_stb     (samp_stb),
  .samp_cnt     (samp_cnt)
);

// File: tb/gdb_debounce_top_tb_top.sv
`timescale 1ns/1ps
module gdb_debounce_top_tb_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    ctrl_code = '0;
  logic          ctrl_src_sel = 1'b0;
  logic          ctrl_clk_en = 1'b0;
  logic          slow_tick = 1'b0;
  logic          sleep = 1'b0;
  logic [NP-1:0] int_en = '0;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_db;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  gdb_debounce_top #(.NUM_PINS(NP)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_code    (ctrl_code),
    .ctrl_src_sel (ctrl_src_sel),
    .ctrl_clk_en  (ctrl_clk_en),
    .slow_tick    (slow_tick),
    .sleep        (sleep),
    .int_en       (int_en),
    .pin_raw      (pin_raw),
    .pin_db       (pin_db)
  );

  task automatic check(input string req, input logic [NP-1:0] exp);
    n_checks++;
    if (pin_db !== exp) begin
      n_errors++;
      $display("FAIL %s: pin_db actual=%b expected=%b at %0t", req, pin_db, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick_slot();
    @(negedge clk) slow_tick = 1'b1;
    @(negedge clk) slow_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #950000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state with raw high
    ctrl_clk_en = 1'b1;
    int_en = 4'b0001;
    pin_raw = 4'b1111;
    do_reset();
    #1 check("R1 reset clear", 4'b0000);

    // R2 / R6: sweep every code on the system clock
    for (int c = 0; c < 16; c++) begin
      ctrl_code = c[3:0];
      ctrl_src_sel = 1'b0;
      ctrl_clk_en = 1'b1;
      sleep = 1'b0;
      int_en = 4'b0001;
      pin_raw = 4'b0011;
      do_reset();
      edges(1 << c);
      check("R2 before second strobe", 4'b0000);
      edges(1);
      check("R2 R6 after second strobe", 4'b0001);
    end

    // R3: slow tick source, code 2
    ctrl_code = 4'd2;
    ctrl_src_sel = 1'b1;
    int_en = 4'b0001;
    pin_raw = 4'b0001;
    do_reset();
    for (int t = 0; t < 4; t++) tick_slot();
    check("R3 four ticks only", 4'b0000);
    tick_slot();
    check("R3 fifth tick", 4'b0001);
    ctrl_src_sel = 1'b0;

    // R4 / R6: gated off, counter must hold
    ctrl_code = 4'd3;
    ctrl_clk_en = 1'b0;
    sleep = 1'b0;
    int_en = 4'b0000;
    pin_raw = 4'b0001;
    do_reset();
    edges(20);
    check("R6 disabled pin holds", 4'b0000);
    int_en = 4'b0001;
    edges(8);
    check("R4 gated counter held, before", 4'b0000);
    edges(1);
    check("R4 gated counter held, after", 4'b0001);

    // R4: enable bit runs the counter with no pin enabled
    ctrl_clk_en = 1'b1;
    int_en = 4'b0000;
    do_reset();
    edges(20);
    int_en = 4'b0001;
    edges(12);
    check("R4 counter ran, before", 4'b0000);
    edges(1);
    check("R4 counter ran, after", 4'b0001);

    // R5: sleep overrides the enable bit
    sleep = 1'b1;
    int_en = 4'b0000;
    do_reset();
    edges(20);
    int_en = 4'b0001;
    edges(8);
    check("R5 sleep held, before", 4'b0000);
    edges(1);
    check("R5 sleep held, after", 4'b0001);
    sleep = 1'b0;

    // R7: glitch rejection at code 0
    ctrl_code = 4'd0;
    int_en = 4'b0001;
    pin_raw = 4'b0000;
    do_reset();
    for (int t = 0; t < 20; t++) @(negedge clk) pin_raw = pin_raw ^ 4'b0001;
    @(negedge clk);
    check("R7 toggling rejected", 4'b0000);
    pin_raw = 4'b0001;
    edges(3);
    check("R7 steady high accepted", 4'b0001);
    @(negedge clk) pin_raw = 4'b0000;
    @(negedge clk) pin_raw = 4'b0001;
    edges(3);
    check("R7 single low sample rejected", 4'b0001);
    // R6: disabled pin keeps a high level
    int_en = 4'b0000;
    pin_raw = 4'b0000;
    edges(10);
    check("R6 disabled keeps high", 4'b0001);
    int_en = 4'b0001;
    edges(1);
    check("R7 first low sample", 4'b0001);
    edges(1);
    check("R7 second low sample", 4'b0000);

    // R8: code change keeps counter phase
    ctrl_code = 4'd0;
    pin_raw = 4'b0000;
    do_reset();
    edges(5);
    ctrl_code = 4'd2;
    pin_raw = 4'b0001;
    edges(7);
    check("R8 new code, before", 4'b0000);
    edges(1);
    check("R8 new code, after", 4'b0001);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule